// File: doc/BRIEF.md
# Comma-Synchronized Byte Scrambler and Descrambler

This block randomizes a byte-wide link datapath before the 8b/10b encoder and restores it on the receive side. Each direction has its own 16-bit linear feedback shift register. Every data byte is XORed bit by bit with eight successive output bits of that register. Because the scheme is additive, the receive lane is the same circuit as the transmit lane: XORing with the same keystream a second time gives back the original byte.

Control symbols are never scrambled. A comma control symbol puts the register back to its seed. Both ends therefore realign at the same point in the stream with no extra signalling. Other control symbols advance the register just as data bytes do. Each lane accepts one byte per clock under a valid strobe and returns its result on the next clock. On clocks without valid, the register keeps its state.

Top module: `scr_link_pair`

## Requirements
- R1: While rst_ni is low, both valid outputs are 0. After reset, the register holds the seed 16'hFFFF, so the first data byte is scrambled with the keystream that starts from the seed.
- R2: An accepted data byte (ctrl low) comes out on the next clock as the input XOR the 8-bit keystream. Output bit i uses keystream bit i, and bit 0 is scrambled first.
- R3: Producing one keystream bit works as follows. The bit is state bit 15. The state then shifts left by one, and if the bit shifted out was 1, the state is XORed with 16'h0039 (polynomial x^16+x^5+x^4+x^3+1). Each accepted byte takes 8 such steps.
- R4: An accepted control symbol (ctrl high) other than the comma leaves the block unchanged, with ctrl_o high, and the register advances 8 steps.
- R5: The comma is ctrl high with byte 8'hBC. It leaves the block unchanged, and the register is reloaded with the seed instead of advancing.
- R6: On a clock with valid low the register keeps its state, so the next accepted byte uses the keystream that was pending.
- R7: Feeding the transmit lane outputs into the receive lane returns the original byte and control stream exactly, including after comma realignment.
- R8: A data byte of 8'h00 or of 8'hFF sent right after reset or after a comma comes out different from its input.
- R9: valid_o and ctrl_o equal the valid and ctrl inputs of the previous clock. valid_o is 0 after an idle input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 8 | Byte to scramble |
| tx_ctrl_i | input | 1 | High when the byte is a control symbol |
| tx_valid_i | input | 1 | Transmit input strobe |
| tx_data_o | output | 8 | Scrambled byte |
| tx_ctrl_o | output | 1 | Control flag of the scrambled byte |
| tx_valid_o | output | 1 | Transmit output strobe |
| rx_data_i | input | 8 | Byte to descramble |
| rx_ctrl_i | input | 1 | Control flag of the received byte |
| rx_valid_i | input | 1 | Receive input strobe |
| rx_data_o | output | 8 | Descrambled byte |
| rx_ctrl_o | output | 1 | Control flag of the descrambled byte |
| rx_valid_o | output | 1 | Receive output strobe |

## Verification
Inputs are driven on the falling edge. The transmit result for that input is registered on the next rising edge and is checked on the falling edge that follows. The bench joins the transmit outputs to the receive inputs, which adds one more register, so each receive result is checked one falling edge later against the input from two edges earlier. The bench's expected scrambled value comes from its own step-by-step model of the register. That model advances only on accepted bytes, reloads the seed on a comma, and is left alone on idle clocks. In this way the skipped and reloaded steps show up directly in the transmit bytes.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_DATA_W = 8;
  localparam int unsigned SCR_LFSR_W = 16;
  localparam logic [SCR_LFSR_W-1:0] SCR_SEED  = 16'hFFFF;
  localparam logic [SCR_LFSR_W-1:0] SCR_TAPS  = 16'h0039;
  localparam logic [SCR_DATA_W-1:0] SCR_COMMA = 8'hBC;
endpackage

// File: rtl/scr_keystream.sv
module scr_keystream #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'h0039
) (
  input  logic [LFSR_W-1:0] state_i,
  output logic [DATA_W-1:0] ks_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [DATA_W:0][LFSR_W-1:0] chain;

  assign chain[0] = state_i;

  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    assign ks_o[g]      = chain[g][LFSR_W-1];
    assign chain[g+1]   = {chain[g][LFSR_W-2:0], 1'b0}
                        ^ (chain[g][LFSR_W-1] ? TAPS : '0);
  end

  assign next_o = chain[DATA_W];
endmodule

// File: rtl/scr_lane.sv
module scr_lane #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hFFFF,
  parameter logic [LFSR_W-1:0] TAPS  = 16'h0039,
  parameter logic [DATA_W-1:0] COMMA = 8'hBC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctrl_i,
  input  logic              valid_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ctrl_o,
  output logic              valid_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_adv;
  logic [DATA_W-1:0] ks;
  logic              is_comma;

  scr_keystream #(
    .DATA_W(DATA_W),
    .LFSR_W(LFSR_W),
    .TAPS  (TAPS)
  ) u_ks (
    .state_i(state_q),
    .ks_o   (ks),
    .next_o (state_adv)
  );

  assign is_comma = ctrl_i && (data_i == COMMA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      data_o  <= '0;
      ctrl_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ctrl_o  <= ctrl_i;
        data_o  <= ctrl_i ? data_i : (data_i ^ ks);
        state_q <= is_comma ? SEED : state_adv;
      end
    end
  end

  AST_CTRL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i) |=> (ctrl_o && data_o == $past(data_i))); // R4
  AST_COMMA_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_comma) |=> (state_q == SEED)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q)); // R6
  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_STATE_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R3
endmodule

// File: rtl/scr_link_pair.sv
module scr_link_pair
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W = SCR_DATA_W,
  parameter int unsigned LFSR_W = SCR_LFSR_W,
  parameter logic [LFSR_W-1:0] SEED  = SCR_SEED,
  parameter logic [LFSR_W-1:0] TAPS  = SCR_TAPS,
  parameter logic [DATA_W-1:0] COMMA = SCR_COMMA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_ctrl_i,
  input  logic              tx_valid_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_ctrl_o,
  output logic              tx_valid_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ctrl_i,
  input  logic              rx_valid_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ctrl_o,
  output logic              rx_valid_o
);
  scr_lane #(
    .DATA_W(DATA_W), .LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .COMMA(COMMA)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .ctrl_i (tx_ctrl_i),
    .valid_i(tx_valid_i),
    .data_o (tx_data_o),
    .ctrl_o (tx_ctrl_o),
    .valid_o(tx_valid_o)
  );

  // additive scheme: descrambler is the same lane
  scr_lane #(
    .DATA_W(DATA_W), .LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .COMMA(COMMA)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (rx_data_i),
    .ctrl_i (rx_ctrl_i),
    .valid_i(rx_valid_i),
    .data_o (rx_data_o),
    .ctrl_o (rx_ctrl_o),
    .valid_o(rx_valid_o)
  );

  AST_TX_RX_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ctrl_i) |=> (rx_valid_o && rx_ctrl_o)); // R9
endmodule

// File: tb/scr_link_pair_tb.sv
module scr_link_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ctrl = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data_o, rx_data_o;
  logic       tx_ctrl_o, tx_valid_o, rx_ctrl_o, rx_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_state = 16'hFFFF;
  logic [7:0]  prev_data = '0;
  logic        prev_ctrl = 1'b0;
  logic        prev_valid = 1'b0;

  always #4 clk = ~clk;

  scr_link_pair u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tx_data_i (tx_data),
    .tx_ctrl_i (tx_ctrl),
    .tx_valid_i(tx_valid),
    .tx_data_o (tx_data_o),
    .tx_ctrl_o (tx_ctrl_o),
    .tx_valid_o(tx_valid_o),
    .rx_data_i (tx_data_o),
    .rx_ctrl_i (tx_ctrl_o),
    .rx_valid_i(tx_valid_o),
    .rx_data_o (rx_data_o),
    .rx_ctrl_o (rx_ctrl_o),
    .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of R3: 8 steps, bit 0 first
  function automatic logic [7:0] model_ks(input logic [15:0] s);
    logic [15:0] t = s;
    logic [7:0]  k;
    for (int i = 0; i < 8; i++) begin
      k[i] = t[15];
      t = (t << 1) ^ (t[15] ? 16'h0039 : 16'h0000);
    end
    return k;
  endfunction

  function automatic logic [15:0] model_next(input logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < 8; i++) t = (t << 1) ^ (t[15] ? 16'h0039 : 16'h0000);
    return t;
  endfunction

  // drive at falling edge, check next falling edge
  task automatic send(input logic [7:0] d, input logic c, input logic v, input string req);
    logic [7:0] exp_d;
    exp_d = c ? d : d ^ model_ks(m_state);
    tx_data = d; tx_ctrl = c; tx_valid = v;
    @(negedge clk);
    chk(tx_valid_o == v, "R9 tx_valid", {15'd0, tx_valid_o}, {15'd0, v});
    if (v) begin
      chk(tx_data_o == exp_d && tx_ctrl_o == c, req, {7'd0, tx_ctrl_o, tx_data_o}, {7'd0, c, exp_d});
      if (c && d == 8'hBC) m_state = 16'hFFFF;
      else m_state = model_next(m_state);
    end
    chk(rx_valid_o == prev_valid, "R9 rx_valid", {15'd0, rx_valid_o}, {15'd0, prev_valid});
    if (prev_valid)
      chk(rx_data_o == prev_data && rx_ctrl_o == prev_ctrl, "R7 roundtrip",
          {7'd0, rx_ctrl_o, rx_data_o}, {7'd0, prev_ctrl, prev_data});
    prev_data = d; prev_ctrl = c; prev_valid = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_valid_o == 1'b0 && rx_valid_o == 1'b0, "R1 reset valid",
        {14'd0, tx_valid_o, rx_valid_o}, 16'd0);
    rst_n = 1'b1;
    // R1/R8: first byte from seed
    send(8'h00, 1'b0, 1'b1, "R1 seed byte");
    chk(tx_data_o != 8'h00, "R8 zero differs", {8'd0, tx_data_o}, 16'h0000);
    // R2/R3: full byte sweep
    for (int i = 0; i < 256; i++) send(i[7:0], 1'b0, 1'b1, "R2 data sweep");
    // R4: non-comma control symbols
    send(8'h1C, 1'b1, 1'b1, "R4 ctrl pass");
    send(8'h55, 1'b0, 1'b1, "R4 advance after ctrl");
    send(8'hF7, 1'b1, 1'b1, "R4 ctrl pass");
    // R5/R8: comma then constant bytes
    send(8'hBC, 1'b1, 1'b1, "R5 comma pass");
    send(8'hFF, 1'b0, 1'b1, "R5 seed after comma");
    chk(tx_data_o != 8'hFF, "R8 ones differ", {8'd0, tx_data_o}, 16'h00FF);
    for (int i = 0; i < 20; i++) send(8'h00, 1'b0, 1'b1, "R3 zero run");
    send(8'hBC, 1'b1, 1'b1, "R5 comma pass");
    for (int i = 0; i < 20; i++) send(8'hFF, 1'b0, 1'b1, "R3 ones run");
    // R6: idle gaps, data must not change keystream
    for (int i = 0; i < 40; i++) begin
      send(8'hA5 ^ i[7:0], 1'b0, (i % 3) != 1, "R6 idle hold");
    end
    send(8'hBC, 1'b1, 1'b0, "R6 idle comma ignored");
    send(8'h3C, 1'b0, 1'b1, "R6 no reload on idle");
    // mixed stream, R7 roundtrip across commas
    for (int i = 0; i < 200; i++) begin
      logic [7:0] d = (i[7:0] * 8'd37) ^ 8'h6B;
      if (i % 17 == 5)       send(8'hBC, 1'b1, 1'b1, "R5 comma mix");
      else if (i % 13 == 7)  send(8'h7C, 1'b1, 1'b1, "R4 ctrl mix");
      else                   send(d, 1'b0, (i % 11) != 3, "R7 mix");
    end
    send(8'h00, 1'b0, 1'b0, "R9 drain");
    send(8'h00, 1'b0, 1'b0, "R9 drain");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule